// File: doc/BRIEF.md
# Not-Recently-Used Replacement Unit

This block keeps a single "not recently used" flag for every way of every set in a set-associative cache. The cache controller reports hits (references) and line installs (fills) by set index and way. When it needs to evict, it presents a set index on the victim request and reads back a way number in the same cycle. The block holds no tags and no data, and it has no hit logic.

A cleared flag marks a block that was touched recently. A set flag marks a block that may be evicted. A reference or a fill clears the flag of the block it names. A victim request picks among the flagged ways. If no way in the set is flagged, the same request raises every flag in that set and then picks a way. The default pick takes the lowest-numbered flagged way. A parameter selects a rotating variant instead: the search starts at a pointer that moves past each chosen way. Reset raises every flag, so an empty cache fills from way 0 upward. A read port shows the flags of any set.

Top module: `nru_repl`

## Requirements
- R1: After reset every flag of every set reads 1 on `obs_bits`, where bit k of `obs_bits` is the flag of way k of the set on `obs_set`.
- R2: A fill clears the flag of the named way in the named set on the next clock edge and leaves the other flags of that set unchanged.
- R3: A reference clears the flag of the named way in the named set on the next clock edge and leaves the other flags of that set unchanged.
- R4: With `ROTATE`=0 and at least one flag set in the requested set, `vic_way` is the lowest way number whose flag is 1, and the request leaves the flags unchanged.
- R5: When every flag of the requested set is 0, the request sets all flags of that set to 1 on the next edge. With `ROTATE`=0 it returns way 0.
- R6: When a reference or a fill to the same set arrives in the same cycle as a victim request, the victim is chosen from the flags as they were before the edge. The set-all of R5 is applied first, and then the reference and fill clears.
- R7: With `ROTATE`=1, the search begins at a pointer that resets to 0. It returns the first way with flag 1 at or after the pointer, wrapping modulo the number of ways, or returns the pointer itself when the set is empty. After each request the pointer moves to the chosen way plus 1, modulo the number of ways.
- R8: `vic_way` is a combinational function of `vic_set` and the stored flags, valid in the same cycle as `vic_valid`.
- R9: Sets that no reference, fill or victim request names keep their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A hit occurred on `ref_set`/`ref_way` |
| ref_set | input | SET_W | Set of the hit |
| ref_way | input | WAY_W | Way of the hit |
| fill_valid | input | 1 | A line was installed at `fill_set`/`fill_way` |
| fill_set | input | SET_W | Set of the install |
| fill_way | input | WAY_W | Way of the install |
| vic_valid | input | 1 | A victim is requested for `vic_set` |
| vic_set | input | SET_W | Set needing a victim |
| vic_way | output | WAY_W | Chosen victim way |
| obs_set | input | SET_W | Set whose flags are shown |
| obs_bits | output | NUM_WAYS | Flags of `obs_set`, bit k is way k |

## Verification
The assertions take for granted that every set index is below NUM_SETS and every way index is below NUM_WAYS whenever its valid is high, and that set and way inputs carry no unknown bits while their valid is high. The bench draws all indices from a 4-way, 4-set configuration whose index widths cover exactly those ranges. It drives every input from the bench's own reference model, so the stimulus never leaves the legal space. The random phase sends references, fills and victim requests that collide in the same set, while directed steps empty sets completely, so that both the set-all case and the ordering rule are reached in each picking variant.

// File: rtl/nru_pkg.sv
package nru_pkg;

  localparam int NRU_MAX_WAYS = 64;

  typedef logic [NRU_MAX_WAYS-1:0] nru_vec_t;

  // First index at or after start (cyclic over n) whose bit is 1; start when none.
  function automatic int nru_first_from(nru_vec_t v, int n, int start);
    int  pick;
    bit  found;
    pick  = start;
    found = 1'b0;
    for (int k = 0; k < NRU_MAX_WAYS; k++) begin
      int idx;
      idx = (start + k) % n;
      if (k < n && !found && v[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  // Successor of w modulo n.
  function automatic int nru_wrap_inc(int w, int n);
    return (w + 1 >= n) ? 0 : w + 1;
  endfunction

endpackage

// File: rtl/nru_bit_array.sv
module nru_bit_array #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_valid,
  input  logic [SET_W-1:0]             ref_set,
  input  logic [WAY_W-1:0]             ref_way,
  input  logic                         fill_valid,
  input  logic [SET_W-1:0]             fill_set,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic                         vic_valid,
  input  logic [SET_W-1:0]             vic_set,
  input  logic [SET_W-1:0]             obs_set,
  output logic [NUM_WAYS-1:0]          vic_bits,
  output logic [NUM_WAYS-1:0]          obs_bits,
  output logic [NUM_SETS*NUM_WAYS-1:0] state_flat
);

  logic [NUM_WAYS-1:0] rows [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_WAYS-1:0] flags_q;
    logic [NUM_WAYS-1:0] flags_d;
    logic                hit_vic;
    logic                hit_ref;
    logic                hit_fill;

    assign hit_vic  = vic_valid  && (vic_set  == SET_W'(s));
    assign hit_ref  = ref_valid  && (ref_set  == SET_W'(s));
    assign hit_fill = fill_valid && (fill_set == SET_W'(s));

    // Set-all first, then the clears of references and fills.
    always_comb begin
      flags_d = flags_q;
      if (hit_vic && (flags_q == '0)) flags_d = '1;
      if (hit_ref)  flags_d[ref_way]  = 1'b0;
      if (hit_fill) flags_d[fill_way] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '1;
      else        flags_q <= flags_d;
    end

    assign rows[s] = flags_q;
    assign state_flat[s*NUM_WAYS +: NUM_WAYS] = flags_q;
  end

  assign vic_bits = rows[vic_set];
  assign obs_bits = rows[obs_set];

endmodule

// File: rtl/nru_victim_pick.sv
module nru_victim_pick
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] cand,
  input  logic [WAY_W-1:0]    start_way,
  output logic [WAY_W-1:0]    way,
  output logic                empty
);

  nru_vec_t ext;

  always_comb begin
    ext                 = '0;
    ext[NUM_WAYS-1:0]   = cand;
  end

  assign empty = ~|cand;
  // An empty set is treated as all-ones, whose first hit is start_way itself.
  assign way   = WAY_W'(nru_first_from(ext, NUM_WAYS, int'(start_way)));

endmodule

// File: rtl/nru_rot_ptr.sv
module nru_rot_ptr
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [WAY_W-1:0] taken_way,
  output logic [WAY_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= WAY_W'(nru_wrap_inc(int'(taken_way), NUM_WAYS));
  end

endmodule

// File: rtl/nru_repl.sv
module nru_repl #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 64,
  parameter bit ROTATE   = 1'b0,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_valid,
  input  logic [SET_W-1:0]    ref_set,
  input  logic [WAY_W-1:0]    ref_way,
  input  logic                fill_valid,
  input  logic [SET_W-1:0]    fill_set,
  input  logic [WAY_W-1:0]    fill_way,
  input  logic                vic_valid,
  input  logic [SET_W-1:0]    vic_set,
  output logic [WAY_W-1:0]    vic_way,
  input  logic [SET_W-1:0]    obs_set,
  output logic [NUM_WAYS-1:0] obs_bits
);

  logic [NUM_WAYS-1:0]          vic_bits;
  logic                         vic_empty;
  logic [WAY_W-1:0]             start_way;
  logic [NUM_SETS*NUM_WAYS-1:0] state_flat;

  nru_bit_array #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .ref_set    (ref_set),
    .ref_way    (ref_way),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .fill_way   (fill_way),
    .vic_valid  (vic_valid),
    .vic_set    (vic_set),
    .obs_set    (obs_set),
    .vic_bits   (vic_bits),
    .obs_bits   (obs_bits),
    .state_flat (state_flat)
  );

  if (ROTATE) begin : g_rotate
    nru_rot_ptr #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
    ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (vic_valid),
      .taken_way (vic_way),
      .ptr       (start_way)
    );
  end else begin : g_fixed
    assign start_way = '0;
  end

  nru_victim_pick #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W)
  ) u_pick (
    .cand      (vic_bits),
    .start_way (start_way),
    .way       (vic_way),
    .empty     (vic_empty)
  );

endmodule

// File: rtl/nru_repl_chk.sv
module nru_repl_chk #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_SETS = 64,
  parameter bit ROTATE   = 1'b0,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ref_valid,
  input logic [SET_W-1:0]             ref_set,
  input logic [WAY_W-1:0]             ref_way,
  input logic                         fill_valid,
  input logic [SET_W-1:0]             fill_set,
  input logic [WAY_W-1:0]             fill_way,
  input logic                         vic_valid,
  input logic [SET_W-1:0]             vic_set,
  input logic [WAY_W-1:0]             vic_way,
  input logic [NUM_WAYS-1:0]          vic_bits,
  input logic                         vic_empty,
  input logic [NUM_SETS*NUM_WAYS-1:0] state_flat
);

  logic [NUM_WAYS-1:0] rows [NUM_SETS];
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_row
    assign rows[s] = state_flat[s*NUM_WAYS +: NUM_WAYS];
  end

  // R4
  victim_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && !vic_empty |-> vic_bits[vic_way]);

  // R3
  ref_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> rows[$past(ref_set)][$past(ref_way)] == 1'b0);

  // R2
  fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> rows[$past(fill_set)][$past(fill_way)] == 1'b0);

  // R5
  empty_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && vic_empty && !(ref_valid && ref_set == vic_set)
      && !(fill_valid && fill_set == vic_set)
    |=> rows[$past(vic_set)] == {NUM_WAYS{1'b1}});

  if (!ROTATE) begin : g_fixed_chk
    // R4
    lowest_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid && !vic_empty
      |-> (vic_bits & ((NUM_WAYS'(1) << vic_way) - NUM_WAYS'(1))) == '0);

    // R5
    empty_picks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid && vic_empty |-> vic_way == '0);
  end

endmodule

bind nru_repl nru_repl_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_SETS (NUM_SETS),
  .ROTATE   (ROTATE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_valid  (ref_valid),
  .ref_set    (ref_set),
  .ref_way    (ref_way),
  .fill_valid (fill_valid),
  .fill_set   (fill_set),
  .fill_way   (fill_way),
  .vic_valid  (vic_valid),
  .vic_set    (vic_set),
  .vic_way    (vic_way),
  .vic_bits   (vic_bits),
  .vic_empty  (vic_empty),
  .state_flat (state_flat)
);

// File: tb/nru_repl_tb.sv
module nru_repl_tb;

  localparam int CLK_PERIOD = 20;
  localparam int W = 4;
  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_valid = 1'b0, fill_valid = 1'b0, vic_valid = 1'b0;
  logic [1:0] ref_set = '0, ref_way = '0, fill_set = '0, fill_way = '0;
  logic [1:0] vic_set = '0, obs_set = '0;
  logic [1:0] vic_way_fx, vic_way_rt;
  logic [3:0] obs_fx, obs_rt;

  int total = 0;
  int bad   = 0;
  int mbits [2][S];
  int mptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  nru_repl #(.NUM_WAYS(W), .NUM_SETS(S), .ROTATE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_set(ref_set), .ref_way(ref_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .vic_valid(vic_valid), .vic_set(vic_set), .vic_way(vic_way_fx),
    .obs_set(obs_set), .obs_bits(obs_fx));

  nru_repl #(.NUM_WAYS(W), .NUM_SETS(S), .ROTATE(1'b1)) u_dut_rot (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_set(ref_set), .ref_way(ref_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .vic_valid(vic_valid), .vic_set(vic_set), .vic_way(vic_way_rt),
    .obs_set(obs_set), .obs_bits(obs_rt));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Victim from the model: scan cyclically from the start way.
  function automatic int model_victim(int d, int set);
    int b, start;
    b     = mbits[d][set];
    start = (d == 1) ? mptr : 0;
    for (int k = 0; k < W; k++) begin
      int idx;
      idx = (start + k) % W;
      if (b[idx]) return idx;
    end
    return start;
  endfunction

  task automatic sweep_obs(string req);
    for (int s = 0; s < S; s++) begin
      obs_set = 2'(s);
      #1;
      check(int'(obs_fx) == mbits[0][s], req, int'(obs_fx), mbits[0][s]);
      check(int'(obs_rt) == mbits[1][s], req, int'(obs_rt), mbits[1][s]);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(bit rv, int rs, int rw, bit fv, int fs, int fw,
                      bit vv, int vs, string req);
    int ev [2];
    ref_valid = rv;  ref_set = 2'(rs);  ref_way = 2'(rw);
    fill_valid = fv; fill_set = 2'(fs); fill_way = 2'(fw);
    vic_valid = vv;  vic_set = 2'(vs);
    #1;
    if (vv) begin
      ev[0] = model_victim(0, vs);
      ev[1] = model_victim(1, vs);
      // R8: victim visible in the request cycle
      check(int'(vic_way_fx) == ev[0], {req, " R4 R8 fixed victim"}, int'(vic_way_fx), ev[0]);
      check(int'(vic_way_rt) == ev[1], {req, " R7 rotating victim"}, int'(vic_way_rt), ev[1]);
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      if (vv && mbits[d][vs] == 0) mbits[d][vs] = (1 << W) - 1;
      if (rv) mbits[d][rs] = mbits[d][rs] & ~(1 << rw);
      if (fv) mbits[d][fs] = mbits[d][fs] & ~(1 << fw);
    end
    if (vv) mptr = (ev[1] + 1) % W;
    @(negedge clk);
    ref_valid = 1'b0; fill_valid = 1'b0; vic_valid = 1'b0;
    sweep_obs(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < S; s++) mbits[d][s] = (1 << W) - 1;
    mptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sweep_obs("R1 reset state");

    // Empty-cache fill order on set 0: victim then fill of that way.
    for (int i = 0; i < W; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, 0, "R4 fill order");
      step(0, 0, 0, 1, 0, model_victim(0, 0), 0, 0, "R2 fill victim");
    end
    // Set 0 now fully clear in the fixed model: set-all on request.
    step(0, 0, 0, 0, 0, 0, 1, 0, "R5 set-all");

    // Clear set 1 by references, then request a victim (empty set).
    for (int w = 0; w < W; w++) step(1, 1, w, 0, 0, 0, 0, 0, "R3 ref clear");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R5 empty set victim");

    // Clear set 2, then a victim request with a same-cycle ref and fill.
    for (int w = 0; w < W; w++) step(0, 0, 0, 1, 2, w, 0, 0, "R2 fill clear");
    step(1, 2, 0, 1, 2, 3, 1, 2, "R6 same-cycle order");
    // Non-empty set with a same-cycle reference on the chosen way.
    step(1, 2, 1, 0, 0, 0, 1, 2, "R6 ref on victim way");

    // Random traffic with collisions; set 3 idles for a while.
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2), $urandom_range(0, W-1),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2), $urandom_range(0, W-1),
           $urandom_range(0, 1) == 1, $urandom_range(0, 2), "R9 idle set");
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1) == 1, $urandom_range(0, S-1), $urandom_range(0, W-1),
           $urandom_range(0, 2) == 0, $urandom_range(0, S-1), $urandom_range(0, W-1),
           $urandom_range(0, 1) == 1, $urandom_range(0, S-1), "R6 R7 random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule